// File: doc/BRIEF.md
# Repetitive Pattern Receive Synchronizer

This block is the receive half of a bit-error-rate tester running in repetitive-pattern mode. Serial data arrives one bit per qualified receive strobe. The block looks for any sequence that repeats with a programmed period of 1 to `MAX_LEN` bits and locks onto it. It does not need to know what the far end sent. Once locked, it holds on to the captured word and predicts each following bit from it. It counts every bit received in lock and every bit that differs from the prediction.

A repeat over a divisor of the programmed length also achieves lock. So does a constant stream of zeros or of ones, whatever length is programmed. Software therefore reads the captured word and the constant-stream flags to confirm that the right pattern was found. The captured word may be a rotation of the transmitted one. A burst of errors drops lock and the search starts again. A gating input stops every receive function. The counters are read through a latch request that completes on the next qualified bit.

Top module: `rps_sync_rx`

## Requirements
- R1: `len_i` programs the pattern length L in bits. The values 1 to `MAX_LEN` are used as given, and 0 or any value above `MAX_LEN` is taken as `MAX_LEN`.
- R2: After reset or a loss of lock, the search compares each bit with the bit received L qualified bits earlier. Once L bits of history exist, 2·L consecutive equal comparisons set `sync_o`. For a stream whose period is L or a divisor of L, `sync_o` rises after bit 3·L (counting from 1) and not before.
- R3: In lock, a bit that differs from the bit L positions earlier in the rotating locked pattern adds exactly one to the error counter.
- R4: A constant all-zeros or all-ones stream achieves lock for every programmed length.
- R5: Out of lock, neither counter changes except when a latch clears them.
- R6: In lock, the bit counter increases by one on every qualified bit.
- R7: `all_zero_o` is high exactly when in lock with a captured pattern of all zeros. `all_one_o` is high exactly when in lock with a captured pattern whose low L bits are all ones.
- R8: At lock, `pat_o` takes the last L received bits, newest in bit 0, with the higher bits zero. It then holds this value until the next lock.
- R9: While `rx_gate_i` is high, strobes are ignored. Lock state, history, counters and a pending latch all stay frozen.
- R10: A pulse on `latch_req_i` makes a latch pending. On the next qualified bit, the hold outputs take the counter values from before that bit, the counters restart with only that bit's contribution, and `latch_done_o` pulses for one cycle. After reset, the outputs and hold values are zero.
- R11: Both counters saturate at all ones.
- R12: Lock drops on the bit that brings the number of errors within the last 64 locked bits to 6. Five errors within any 64 bits keep lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive strobe: one bit is taken per high cycle |
| rx_gate_i | input | 1 | Receive disable; freezes all receive functions |
| rx_bit_i | input | 1 | Serial receive data |
| len_i | input | LEN_W | Programmed pattern length |
| latch_req_i | input | 1 | Counter latch request |
| sync_o | output | 1 | Pattern lock |
| all_zero_o | output | 1 | Locked on an all-zeros pattern |
| all_one_o | output | 1 | Locked on an all-ones pattern |
| pat_o | output | MAX_LEN | Captured pattern |
| bit_hold_o | output | CNT_W | Latched bit count |
| err_hold_o | output | CNT_W | Latched error count |
| latch_done_o | output | 1 | One-cycle pulse when a latch completes |

## Verification
On every cycle, the embedded properties check the following:
- gating freezes lock, history and counters;
- counters are stable out of lock;
- the bit counter advances by exactly one per locked bit;
- errors advance by at most one;
- counters never wrap;
- the two constant flags are never high together;
- the loss window stays below its threshold.

Only the bench scenarios can show the following:
- the exact bit on which lock rises for each length, including divisor periods, clamped lengths and constant streams;
- the content of the captured word;
- the exact error and bit totals returned by a latch;
- the precise bit on which the sixth error in a window drops lock.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } rps_state_e;

    localparam int RPS_LOSS_WIN_DEF = 64;
    localparam int RPS_LOSS_THR_DEF = 6;

endpackage

// File: rtl/rps_sat_cnt.sv
module rps_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = (en_i && inc_i) ? W'(1) : '0;
        end else if (en_i && inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '1 && !clr_i) |=> (cnt_q == '1)); // R11

    AST_CNT_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (cnt_q - $past(cnt_q)) <= W'(1)); // R3
endmodule

// File: rtl/rps_err_window.sv
module rps_err_window #(
    parameter int WIN = 64,
    parameter int THR = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic flush_i,
    input  logic err_i,
    output logic lost_o
);
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [WIN-1:0] hist;
        logic [CW-1:0]  cnt;
    } win_t;

    win_t          d, q;
    logic [CW-1:0] cnt_next;

    always_comb begin
        cnt_next = q.cnt + CW'(err_i) - CW'(q.hist[WIN-1]);
        lost_o   = en_i && (cnt_next >= CW'(THR));
        d        = q;
        if (flush_i) begin
            d.hist = '0;
            d.cnt  = '0;
        end else if (en_i) begin
            d.hist = {q.hist[WIN-2:0], err_i};
            d.cnt  = cnt_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    AST_WIN_BELOW_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt < CW'(THR)); // R12
endmodule

// File: rtl/rps_sync_rx.sv
module rps_sync_rx
    import rps_pkg::*;
#(
    parameter int MAX_LEN  = 32,
    parameter int CNT_W    = 32,
    parameter int LOSS_WIN = RPS_LOSS_WIN_DEF,
    parameter int LOSS_THR = RPS_LOSS_THR_DEF,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rx_en_i,
    input  logic               rx_gate_i,
    input  logic               rx_bit_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               latch_req_i,
    output logic               sync_o,
    output logic               all_zero_o,
    output logic               all_one_o,
    output logic [MAX_LEN-1:0] pat_o,
    output logic [CNT_W-1:0]   bit_hold_o,
    output logic [CNT_W-1:0]   err_hold_o,
    output logic               latch_done_o
);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int RUN_W = LEN_W + 1;

    typedef struct packed {
        rps_state_e         st;
        logic [MAX_LEN-1:0] hist;
        logic [LEN_W-1:0]   fill;
        logic [RUN_W-1:0]   run;
        logic [MAX_LEN-1:0] cap;
        logic [MAX_LEN-1:0] refp;
        logic               pend;
        logic               done;
        logic [CNT_W-1:0]   bit_hold;
        logic [CNT_W-1:0]   err_hold;
    } rx_state_t;

    rx_state_t          d, q;
    logic [LEN_W-1:0]   len_eff;
    logic [LEN_W-1:0]   len_m1;
    logic [IDX_W-1:0]   idx;
    logic [MAX_LEN-1:0] mask;
    logic [MAX_LEN-1:0] hist_next;
    logic [RUN_W-1:0]   run_inc;
    logic [RUN_W-1:0]   twice_len;
    logic               step, take, in_lock, cnt_en, exp_bit, lock_err;
    logic               win_lost;
    logic [CNT_W-1:0]   bit_cnt, err_cnt;

    assign len_eff   = ((len_i == '0) || (len_i > LEN_W'(MAX_LEN))) ? LEN_W'(MAX_LEN) : len_i;
    assign len_m1    = len_eff - LEN_W'(1);
    assign idx       = len_m1[IDX_W-1:0];
    assign twice_len = {len_eff, 1'b0};
    assign run_inc   = q.run + RUN_W'(1);
    assign hist_next = {q.hist[MAX_LEN-2:0], rx_bit_i};

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_mask
        assign mask[g] = (g < int'(len_eff));
    end

    assign step     = rx_en_i && !rx_gate_i;
    assign take     = step && q.pend;
    assign in_lock  = (q.st == ST_LOCK);
    assign cnt_en   = step && in_lock;
    assign exp_bit  = q.refp[idx];
    assign lock_err = cnt_en && (rx_bit_i != exp_bit);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.pend = q.pend | latch_req_i;
        if (take) begin
            d.pend     = latch_req_i;
            d.done     = 1'b1;
            d.bit_hold = bit_cnt;
            d.err_hold = err_cnt;
        end
        if (step) begin
            d.hist = hist_next;
            if (!in_lock) begin
                if (q.fill != LEN_W'(MAX_LEN)) d.fill = q.fill + LEN_W'(1);
                if ((q.fill >= len_eff) && (rx_bit_i == q.hist[idx])) begin
                    if (run_inc == twice_len) begin
                        d.st   = ST_LOCK;
                        d.cap  = hist_next & mask;
                        d.refp = hist_next & mask;
                        d.run  = '0;
                    end else begin
                        d.run = run_inc;
                    end
                end else begin
                    d.run = '0;
                end
            end else begin
                d.refp = {q.refp[MAX_LEN-2:0], exp_bit} & mask;
                if (win_lost) begin
                    d.st  = ST_HUNT;
                    d.run = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    rps_sat_cnt #(.W(CNT_W)) i_bit_cnt (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(cnt_en), .clr_i(take),
        .inc_i (1'b1), .cnt_o(bit_cnt)
    );

    rps_sat_cnt #(.W(CNT_W)) i_err_cnt (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(cnt_en), .clr_i(take),
        .inc_i (lock_err), .cnt_o(err_cnt)
    );

    rps_err_window #(.WIN(LOSS_WIN), .THR(LOSS_THR)) i_win (
        .clk_i  (clk_i), .rst_ni(rst_ni), .en_i(cnt_en),
        .flush_i(!in_lock || win_lost), .err_i(lock_err), .lost_o(win_lost)
    );

    assign sync_o       = in_lock;
    assign all_zero_o   = in_lock && (q.cap == '0);
    assign all_one_o    = in_lock && (q.cap == mask);
    assign pat_o        = q.cap;
    assign bit_hold_o   = q.bit_hold;
    assign err_hold_o   = q.err_hold;
    assign latch_done_o = q.done;

    AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_gate_i |=> ($stable(q.st) && $stable(q.hist) && $stable(bit_cnt)
                       && $stable(err_cnt) && !latch_done_o)); // R9

    AST_HOLD_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_lock && !take) |=> ($stable(bit_cnt) && $stable(err_cnt))); // R5

    AST_BIT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_en && !take && bit_cnt != '1) |=> (bit_cnt == $past(bit_cnt) + CNT_W'(1))); // R6

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(all_zero_o && all_one_o)); // R7

    AST_CAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_lock && $past(in_lock)) |-> $stable(pat_o)); // R8
endmodule

// File: tb/test_rps_sync_rx.sv
module test_rps_sync_rx;
    localparam int MAXL = 32;
    localparam int CW   = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_en = 1'b0;
    logic            rx_gate = 1'b0;
    logic            rx_bit = 1'b0;
    logic            latch_req = 1'b0;
    logic [5:0]      len = 6'd1;
    logic            sync, azero, aone, ldone;
    logic [MAXL-1:0] pat;
    logic [CW-1:0]   bhold, ehold;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rps_sync_rx #(.MAX_LEN(MAXL), .CNT_W(CW)) i_rps_sync_rx (
        .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rx_gate_i(rx_gate),
        .rx_bit_i(rx_bit), .len_i(len), .latch_req_i(latch_req),
        .sync_o(sync), .all_zero_o(azero), .all_one_o(aone), .pat_o(pat),
        .bit_hold_o(bhold), .err_hold_o(ehold), .latch_done_o(ldone)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic b);
        rx_bit = b;
        rx_en  = 1'b1;
        @(negedge clk);
        rx_en  = 1'b0;
    endtask

    task automatic do_reset(input int lport);
        rst_n = 1'b0; rx_en = 1'b0; rx_gate = 1'b0; latch_req = 1'b0;
        len = 6'(lport);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_latch();
        latch_req = 1'b1;
        @(negedge clk);
        latch_req = 1'b0;
    endtask

    function automatic logic sb(input logic [31:0] p, input int lp, input int k);
        return p[k % lp];
    endfunction

    function automatic longint cap_of(input logic [31:0] p, input int lp, input int ln, input int klast);
        longint r = 0;
        for (int j = 0; j < ln; j++) r |= longint'(sb(p, lp, klast - j)) << j;
        return r;
    endfunction

    function automatic longint mask_of(input int ln);
        return (longint'(1) << ln) - 1;
    endfunction

    // R2: lock on bit 3*ln of a stream of period lp (lp divides ln)
    task automatic acquire(input logic [31:0] p, input int lp, input int ln, input int lport,
                           input string tag, output int k);
        do_reset(lport);
        for (int i = 0; i < 3 * ln - 1; i++) send(sb(p, lp, i));
        chk($sformatf("R2 %s no early lock", tag), longint'(sync), 0);
        send(sb(p, lp, 3 * ln - 1));
        chk($sformatf("R2 %s lock at 3L", tag), longint'(sync), 1);
        chk($sformatf("R8 %s captured word", tag), longint'(pat), cap_of(p, lp, ln, 3 * ln - 1));
        k = 3 * ln;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all R): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int k;
        int lens[11] = '{1, 2, 3, 4, 5, 6, 7, 8, 13, 31, 32};
        logic [31:0] p;
        bit bad;

        // R10 reset state
        do_reset(4);
        chk("R10 reset sync", longint'(sync), 0);
        chk("R10 reset bit hold", longint'(bhold), 0);
        chk("R10 reset err hold", longint'(ehold), 0);
        chk("R10 reset done", longint'(ldone), 0);

        // R2 R3 R6 R7 R8 R10 sweep over lengths
        foreach (lens[n]) begin
            int l = lens[n];
            longint c;
            p = 32'h9C5A_36E1;
            acquire(p, l, l, l, $sformatf("L=%0d", l), k);
            c = cap_of(p, l, l, 3 * l - 1);
            chk($sformatf("R7 L=%0d zero flag", l), longint'(azero), longint'(c == 0));
            chk($sformatf("R7 L=%0d one flag", l), longint'(aone), longint'(c == mask_of(l)));
            for (int i = 0; i < 40; i++) begin
                send(sb(p, l, k) ^ ((i == 5) || (i == 17) || (i == 33)));
                k++;
            end
            do_latch();
            chk($sformatf("R10 L=%0d no completion without strobe", l), longint'(ldone), 0);
            send(sb(p, l, k)); k++;
            chk($sformatf("R10 L=%0d done pulse", l), longint'(ldone), 1);
            chk($sformatf("R6 L=%0d bit count", l), longint'(bhold), 40);
            chk($sformatf("R3 L=%0d error count", l), longint'(ehold), 3);
            chk($sformatf("R8 L=%0d word held", l), longint'(pat), c);
            @(negedge clk);
            chk($sformatf("R10 L=%0d done one cycle", l), longint'(ldone), 0);
        end

        // R2 divisor period: period 2 with length 6
        acquire(32'h2, 2, 6, 6, "divisor", k);

        // R1 clamp: length port 0 acts as 32
        acquire(32'hD3A1_5F27, 32, 32, 0, "R1 clamp", k);

        // R4 R7 constant streams
        acquire(32'h0, 1, 5, 5, "R4 zeros L5", k);
        chk("R7 zeros flag", longint'(azero), 1);
        chk("R7 zeros one-flag", longint'(aone), 0);
        acquire(32'h1, 1, 7, 7, "R4 ones L7", k);
        chk("R7 ones flag", longint'(aone), 1);
        chk("R7 ones zero-flag", longint'(azero), 0);
        acquire(32'h0, 1, 32, 32, "R4 zeros L32", k);
        chk("R7 zeros L32 flag", longint'(azero), 1);

        // R12 loss window
        p = 32'hB;
        acquire(p, 4, 4, 4, "loss", k);
        for (int i = 0; i < 200; i++) begin
            send(sb(p, 4, k) ^ (i % 13 == 0)); k++;
        end
        chk("R12 five per window keeps lock", longint'(sync), 1);
        for (int i = 0; i < 64; i++) begin send(sb(p, 4, k)); k++; end
        do_latch();
        send(sb(p, 4, k)); k++;
        for (int i = 0; i < 51; i++) begin
            send(sb(p, 4, k) ^ (i % 10 == 0)); k++;
            if (i == 49) chk("R12 lock before sixth error", longint'(sync), 1);
        end
        chk("R12 lock lost on sixth error", longint'(sync), 0);
        do_latch();
        send(sb(p, 4, k)); k++;
        chk("R10 loss latch bits", longint'(bhold), 52);
        chk("R3 loss latch errors", longint'(ehold), 6);
        for (int i = 0; i < 3; i++) begin send(sb(p, 4, k)); k++; end
        do_latch();
        send(sb(p, 4, k)); k++;
        chk("R5 bits held out of lock", longint'(bhold), 0);
        chk("R5 errors held out of lock", longint'(ehold), 0);
        chk("R2 no relock before 2L matches", longint'(sync), 0);

        // R9 gating
        p = 32'h6;
        acquire(p, 3, 3, 3, "gate", k);
        for (int i = 0; i < 10; i++) begin send(sb(p, 3, k)); k++; end
        rx_gate = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            rx_en = 1'b1;
            rx_bit = logic'(i % 2);
            latch_req = (i == 5);
            @(negedge clk);
            if (ldone) bad = 1'b1;
        end
        rx_en = 1'b0; latch_req = 1'b0; rx_gate = 1'b0;
        chk("R9 no latch completion while gated", longint'(bad), 0);
        chk("R9 lock kept while gated", longint'(sync), 1);
        send(sb(p, 3, k)); k++;
        chk("R9 pending latch completes after gate", longint'(ldone), 1);
        chk("R9 bit count frozen", longint'(bhold), 10);
        chk("R9 no errors from gated data", longint'(ehold), 0);

        // R11 saturation
        p = 32'h1;
        acquire(p, 2, 2, 2, "sat", k);
        for (int i = 0; i < 1100; i++) begin send(sb(p, 2, k)); k++; end
        do_latch();
        send(sb(p, 2, k)); k++;
        chk("R11 bit count saturates", longint'(bhold), (1 << CW) - 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule